// File: doc/BRIEF.md
# Serial Leading-One Fixed-Point Normalizer

This block prepares an unsigned fixed-point operand for a logarithm approximation stage. The operand has INT_W integer bits and FRAC_W fraction bits. The block shifts it left by one bit per clock until its top bit is set. It keeps a signed exponent that starts at INT_W and goes down by one with every shift. The result is a pure fraction in [0.5, 1) with no integer bits, cut to OUT_W bits, delivered together with the exponent. The original value equals the fraction times two to the power of the exponent.

A producer hands in operands on a request/acknowledge pair. A consumer takes results on a second request/acknowledge pair. Latency varies with the operand: an operand whose top bit is already set needs no shift steps, and the operand 1 needs the most. An all-zero operand has no logarithm. It is finished at once and marked with an error flag instead of searching forever.

Top module: `serial_msb_normalizer`

## Requirements
- R1: While reset is held, and right after it is released, out_req is 0, out_err is 0, and in_ack is 0 when in_req is 0.
- R2: When the block is idle and in_req is 1, in_ack is 1 in that same cycle. The operand on in_op is captured at that clock edge.
- R3: For a nonzero operand with z leading zeros (counted over INT_W+FRAC_W bits), out_exp is the signed value INT_W − z, in two's complement.
- R4: out_req rises exactly z clock edges after the edge where the operand was accepted. An operand with bit INT_W+FRAC_W−1 set gives out_req right after the accept edge.
- R5: For a nonzero operand, out_frac holds the top OUT_W bits of the operand shifted left by z. Bit OUT_W−1 of out_frac is 1.
- R6: The operand 1 takes the longest case: INT_W+FRAC_W−1 shift steps, with out_exp = 1 − FRAC_W.
- R7: An all-zero operand raises out_req right after the accept edge with out_err = 1, out_frac = 0 and out_exp = INT_W. A nonzero operand gives out_err = 0.
- R8: While out_req is 1 and out_ack is 0, out_req, out_frac, out_exp and out_err do not change. After an edge that samples out_ack = 1, out_req is 0.
- R9: While a result is pending, a new in_req is not acknowledged and does not change the pending result.
- R10: Operand bits that fall below the OUT_W-bit window after normalization are dropped without rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_req | input | 1 | Producer has an operand on in_op |
| in_ack | output | 1 | Operand accepted at this clock edge |
| in_op | input | INT_W+FRAC_W | Unsigned fixed-point operand |
| out_req | output | 1 | Result is valid and held |
| out_ack | input | 1 | Consumer takes the result at this clock edge |
| out_frac | output | OUT_W | Normalized fraction, weight of MSB is 1/2 |
| out_exp | output | $clog2(INT_W+FRAC_W+1)+1 | Signed exponent |
| out_err | output | 1 | Operand was zero, so it is outside the logarithm domain |

## Verification
The hardest situation to reach from the ports is an operand arriving while a result is still waiting for its consumer. The bench creates it by leaving out_ack low after a slow operand completes, then raising in_req with a different operand. Across several cycles it checks that in_ack stays low and that the held fraction and exponent do not move. The exact latency is measured edge by edge for every leading-zero count tried. This includes the zero operand and the operand 1, which sit at the two ends of the shift-count range.

// File: rtl/msbn_pkg.sv
`timescale 1ns/1ps
package msbn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_HOLD = 2'd2
  } seek_state_e;
endpackage

// File: rtl/msbn_ctrl.sv
`timescale 1ns/1ps
module msbn_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic out_ack,
  input  logic op_zero,
  input  logic op_top,
  input  logic work_next_top,
  output logic load_en,
  output logic shift_en,
  output logic in_ack,
  output logic out_req
);
  import msbn_pkg::*;

  seek_state_e state_q, state_nx;

  always_comb begin
    state_nx = state_q;
    load_en  = 1'b0;
    shift_en = 1'b0;
    in_ack   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_req) begin
          in_ack  = 1'b1;
          load_en = 1'b1;
          // zero or already-normalized operands skip the search
          state_nx = (op_zero || op_top) ? ST_HOLD : ST_SEEK;
        end
      end
      ST_SEEK: begin
        shift_en = 1'b1;
        // look one bit ahead so the last shift lands straight in HOLD
        if (work_next_top) state_nx = ST_HOLD;
      end
      ST_HOLD: begin
        if (out_ack) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nx;
  end

  assign out_req = (state_q == ST_HOLD);

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !in_ack) else $error("load while busy"); // R9
endmodule

// File: rtl/msbn_shift.sv
`timescale 1ns/1ps
module msbn_shift #(
  parameter int INT_W = 8,
  parameter int OP_W  = 16,
  parameter int EXP_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic                    shift_en,
  input  logic [OP_W-1:0]         operand,
  output logic [OP_W-1:0]         work,
  output logic signed [EXP_W-1:0] exp_val,
  output logic                    zero_flag
);
  localparam logic signed [EXP_W-1:0] EXP_START = EXP_W'(INT_W);
  localparam logic signed [EXP_W-1:0] EXP_FLOOR = EXP_W'(INT_W - (OP_W - 1));

  logic [OP_W-1:0]         work_q, work_nx;
  logic signed [EXP_W-1:0] exp_q, exp_nx;
  logic                    zero_q, zero_nx;

  always_comb begin
    work_nx = work_q;
    exp_nx  = exp_q;
    zero_nx = zero_q;
    if (load_en) begin
      work_nx = operand;
      exp_nx  = EXP_START;
      zero_nx = (operand == '0);
    end else if (shift_en) begin
      work_nx = {work_q[OP_W-2:0], 1'b0};
      exp_nx  = exp_q - EXP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      exp_q  <= '0;
      zero_q <= 1'b0;
    end else if (load_en || shift_en) begin
      work_q <= work_nx;
      exp_q  <= exp_nx;
      zero_q <= zero_nx;
    end
  end

  assign work      = work_q;
  assign exp_val   = exp_q;
  assign zero_flag = zero_q;

  AST_EXP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && !load_en |=> exp_q == $past(exp_q) - EXP_W'(1)) else $error("exp step"); // R3
  AST_EXP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> exp_q > EXP_FLOOR) else $error("exp below floor"); // R6
endmodule

// File: rtl/msbn_trunc.sv
`timescale 1ns/1ps
module msbn_trunc #(
  parameter int OP_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic [OP_W-1:0]  work,
  output logic [OUT_W-1:0] frac
);
  generate
    if (OUT_W <= OP_W) begin : g_cut
      assign frac = work[OP_W-1 -: OUT_W];
      if (OUT_W < OP_W) begin : g_drop
        logic unused_low;
        assign unused_low = ^work[OP_W-OUT_W-1:0];
      end
    end else begin : g_pad
      assign frac = {work, {(OUT_W-OP_W){1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/serial_msb_normalizer.sv
`timescale 1ns/1ps
module serial_msb_normalizer #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 12,
  localparam int OP_W  = INT_W + FRAC_W,
  localparam int EXP_W = $clog2(OP_W + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_req,
  output logic                    in_ack,
  input  logic [OP_W-1:0]         in_op,
  output logic                    out_req,
  input  logic                    out_ack,
  output logic [OUT_W-1:0]        out_frac,
  output logic signed [EXP_W-1:0] out_exp,
  output logic                    out_err
);
  logic            load_en, shift_en;
  logic [OP_W-1:0] work;

  msbn_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_req        (in_req),
    .out_ack       (out_ack),
    .op_zero       (in_op == '0),
    .op_top        (in_op[OP_W-1]),
    .work_next_top (work[OP_W-2]),
    .load_en       (load_en),
    .shift_en      (shift_en),
    .in_ack        (in_ack),
    .out_req       (out_req)
  );

  msbn_shift #(.INT_W(INT_W), .OP_W(OP_W), .EXP_W(EXP_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .shift_en  (shift_en),
    .operand   (in_op),
    .work      (work),
    .exp_val   (out_exp),
    .zero_flag (out_err)
  );

  msbn_trunc #(.OP_W(OP_W), .OUT_W(OUT_W)) u_trunc (
    .work (work),
    .frac (out_frac)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_ack |=> out_req && $stable(out_frac) && $stable(out_exp) && $stable(out_err))
    else $error("held result moved"); // R8
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && out_ack |=> !out_req) else $error("request stuck"); // R8
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> !in_ack) else $error("accepted while busy"); // R9
  AST_FRAC_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_err |-> out_frac[OUT_W-1]) else $error("fraction not normalized"); // R5
  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && out_err |-> out_frac == '0 && out_exp == EXP_W'(INT_W)) else $error("zero result"); // R7
endmodule

// File: tb/test_serial_msb_normalizer.sv
`timescale 1ns/1ps
module test_serial_msb_normalizer;
  localparam int INT_W  = 8;
  localparam int FRAC_W = 8;
  localparam int OUT_W  = 12;
  localparam int OP_W   = INT_W + FRAC_W;
  localparam int EXP_W  = $clog2(OP_W + 1) + 1;

  logic clk = 1'b0;
  logic rst_n, in_req, in_ack, out_req, out_ack, out_err;
  logic [OP_W-1:0] in_op;
  logic [OUT_W-1:0] out_frac;
  logic signed [EXP_W-1:0] out_exp;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  serial_msb_normalizer #(.INT_W(INT_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) i_serial_msb_normalizer (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack), .in_op(in_op),
    .out_req(out_req), .out_ack(out_ack), .out_frac(out_frac), .out_exp(out_exp), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int lead_zeros(input logic [OP_W-1:0] v);
    int z = 0;
    for (int b = OP_W - 1; b >= 0; b--) begin
      if (v[b]) break;
      z++;
    end
    if (v == '0) z = 0;
    return z;
  endfunction

  function automatic logic [OUT_W-1:0] ref_frac(input logic [OP_W-1:0] v);
    logic [OP_W-1:0] n = v << lead_zeros(v);
    return n[OP_W-1 -: OUT_W];
  endfunction

  // submit, measure latency, check result; leaves result pending
  task automatic submit(input logic [OP_W-1:0] op, input string tag, output int lat);
    @(negedge clk);
    in_op = op; in_req = 1'b1;
    #1 chk(in_ack == 1'b1, {"R2 ", tag}, in_ack, 1);
    @(posedge clk); #1;
    in_req = 1'b0;
    lat = 0;
    while (!out_req && lat < 64) begin
      @(posedge clk); #1;
      lat++;
    end
  endtask

  task automatic release_result(input string tag);
    @(negedge clk); out_ack = 1'b1;
    @(posedge clk); #1;
    out_ack = 1'b0;
    chk(out_req == 1'b0, {"R8 drop ", tag}, out_req, 0);
  endtask

  task automatic t_normal(input logic [OP_W-1:0] op, input string tag);
    int lat;
    int z = lead_zeros(op);
    submit(op, tag, lat);
    chk(lat == z, {"R4 latency ", tag}, lat, z);
    chk(int'(out_exp) == INT_W - z, {"R3 exp ", tag}, int'(out_exp), INT_W - z);
    chk(out_frac == ref_frac(op), {"R5 frac ", tag}, out_frac, ref_frac(op));
    chk(out_err == 1'b0, {"R7 err ", tag}, out_err, 0);
    release_result(tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_req = 1'b0; out_ack = 1'b0; in_op = '0;
    repeat (3) @(posedge clk);
    #1 chk(out_req == 1'b0 && out_err == 1'b0 && in_ack == 1'b0, "R1 in reset", out_req, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(out_req == 1'b0 && out_err == 1'b0 && in_ack == 1'b0, "R1 after reset", out_req, 0);
  endtask

  task automatic t_zero;
    int lat;
    submit('0, "zero", lat);
    chk(lat == 0, "R7 zero latency", lat, 0);
    chk(out_err == 1'b1, "R7 zero err", out_err, 1);
    chk(out_frac == '0, "R7 zero frac", out_frac, 0);
    chk(int'(out_exp) == INT_W, "R7 zero exp", int'(out_exp), INT_W);
    release_result("zero");
  endtask

  task automatic t_worst;
    int lat;
    submit(OP_W'(1), "one", lat);
    chk(lat == OP_W - 1, "R6 worst latency", lat, OP_W - 1);
    chk(int'(out_exp) == 1 - FRAC_W, "R6 worst exp", int'(out_exp), 1 - FRAC_W);
    chk(out_frac == {1'b1, {(OUT_W-1){1'b0}}}, "R6 worst frac", out_frac, 1 << (OUT_W-1));
    release_result("one");
  endtask

  task automatic t_trunc;
    // 0x00FF: 8 leading zeros; normalized 0xFF00 -> top 12 bits 0xFF0
    // 0x8FFF: no shift; low 4 bits dropped -> 0x8FF, not rounded up
    t_normal(16'h00FF, "R10 trunc a");
    t_normal(16'h8FFF, "R10 trunc b");
  endtask

  task automatic t_busy_hold;
    int lat;
    logic [OUT_W-1:0] f0;
    logic signed [EXP_W-1:0] e0;
    submit(16'h0003, "busy", lat);
    f0 = out_frac; e0 = out_exp;
    @(negedge clk);
    in_op = 16'h8000; in_req = 1'b1;
    #1 chk(in_ack == 1'b0, "R9 no ack while pending", in_ack, 0);
    repeat (3) begin
      @(posedge clk); #1;
      chk(out_req == 1'b1 && out_frac == f0 && out_exp == e0, "R8 R9 held stable", out_frac, f0);
    end
    @(negedge clk); in_req = 1'b0; out_ack = 1'b1;
    @(posedge clk); #1;
    out_ack = 1'b0;
    chk(out_req == 1'b0, "R8 drop after busy", out_req, 0);
  endtask

  initial begin
    t_reset();
    t_normal(16'h8001, "msb set");
    t_normal(16'h4000, "one zero");
    t_normal(16'h0123, "mid");
    t_normal(16'h0100, "integer one");
    t_normal(16'h0080, "half");
    t_worst();
    t_zero();
    t_trunc();
    t_busy_hold();
    t_normal(16'h0003, "after busy");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule